// File: doc/BRIEF.md
# I2C Slave Receiver with Own-Address Recognition

This block is the receive-only target side of an I2C controller. It watches SCL and SDA through synchronisers, spots START and STOP conditions, and shifts in the address byte that follows every START. If the top seven bits equal a programmable own address and the direction bit is write, it pulls SDA low for the acknowledge clock. This happens only while the block is enabled, the acknowledge-enable bit is set, and neither the start-request bit nor the stop-request bit is set. After that it takes data bytes. For each byte it returns ACK or NACK according to the acknowledge-enable bit at the moment the eighth bit ends.

Every event raises an interrupt flag and posts a status code. After an acknowledge clock the block also holds SCL low until the host clears the flag, so the host can take as long as it needs. A single acknowledge-enable bit decides both whether the own address is recognised and whether the next data byte is acknowledged. Clearing it cuts the device off from the bus, but START and STOP tracking carries on, so recognition resumes at the next address once the bit is set again.

The host reaches four byte-wide registers through a simple write strobe and a combinational read port.

Top module: `i2c_target_rx`

## Requirements
- R1: Register index 0 holds the own address in bits 7..1, and bit 0 always reads 0.
- R2: The address byte after a START is acknowledged only under all of these conditions: its bits 7..1 equal the own address, its bit 0 is 0 (write), and the control register (index 1) has bit 7 (enable) = 1, bit 6 (ack-enable) = 1, bit 5 (start request) = 0 and bit 4 (stop request) = 0. On that acknowledge the flag (control bit 3, and the `irq` port) rises with status 60h.
- R3: An address that is not acknowledged raises no flag, and the bytes that follow are ignored (no ACK, no flag) until the next START.
- R4: While addressed, a data byte received with ack-enable = 1 gets an ACK and status 80h, and the byte can be read at index 3.
- R5: A data byte received with ack-enable = 0 gets a NACK (SDA left high), status 88h and the byte at index 3. The block then becomes unaddressed: later bytes and a STOP raise no flag.
- R6: With ack-enable = 0 the own address is not acknowledged. Setting ack-enable again, with no reset, makes the next matching address acknowledged.
- R7: After each acknowledge clock that ends with a flag, SCL is held low while the flag is set and released once the host clears it by writing 0 to control bit 3.
- R8: A STOP or a repeated START seen while addressed raises the flag with status A0h and does not hold SCL. The address that follows a repeated START is recognised as in R2.
- R9: After reset the flag is 0, neither bus line is driven, the control register reads 00h, and while the flag is 0 the status register (index 2) reads F8h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_en | input | 1 | Host register write strobe |
| wr_idx | input | 2 | Register index for a write |
| wr_data | input | 8 | Host write data |
| rd_idx | input | 2 | Register index for a read |
| rd_data | output | 8 | Read data for `rd_idx` |
| irq | output | 1 | Interrupt flag (control bit 3) |

## Verification
The assertions assume that the other bus party keeps SCL low while SDA changes, except when it signals START or STOP. They also assume that the host writes the control register only while SCL is held or the bus is idle, never in the cycle an acknowledge is decided. They further assume that SCL phases last many system clocks, so a detected falling edge comes before the next bit. The bench's master model follows these rules: it changes SDA a quarter-bit after SCL falls, waits for SCL to be released before counting a high phase, and performs every host write while the block is stalling SCL or the bus is idle.

// File: rtl/i2c_srx_pkg.sv
// Shared encodings for the I2C slave receiver: engine states, status
// codes, register indices and control-bit positions.
package i2c_srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD,
        ST_DATA
    } srx_state_e;

    localparam logic [7:0] CODE_ADDR_ACK  = 8'h60;
    localparam logic [7:0] CODE_DATA_ACK  = 8'h80;
    localparam logic [7:0] CODE_DATA_NACK = 8'h88;
    localparam logic [7:0] CODE_END       = 8'hA0;
    localparam logic [7:0] CODE_IDLE      = 8'hF8;

    localparam logic [1:0] IDX_OWN  = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam logic [1:0] IDX_STAT = 2'd2;
    localparam logic [1:0] IDX_DATA = 2'd3;

    localparam int CB_EN   = 7;
    localparam int CB_AA   = 6;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_FLAG = 3;

endpackage

// File: rtl/i2c_srx_sync.sv
// Multi-stage synchroniser for a group of asynchronous bus lines.
// Assumes the lines idle high, so every stage resets to 1.
module i2c_srx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_in[g]};
        end

        assign d_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c_srx_cond.sv
// Bus condition detector: SCL edges plus START (SDA falls while SCL high)
// and STOP (SDA rises while SCL high). Inputs must already be synchronised.
module i2c_srx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_srx_engine.sv
// Receive engine: shifts the address and data bytes, decides ACK/NACK,
// posts status events and stalls SCL after each acknowledge clock.
// Assumes condition strobes are single-cycle and SCL phases span many clocks.
module i2c_srx_engine
    import i2c_srx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            aa,
    input  logic            sta_req,
    input  logic            sto_req,
    input  logic            si,
    input  logic [BITS-2:0] own_addr,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    output logic            sda_drive,
    output logic            scl_hold,
    output logic            set_si,
    output logic [7:0]      set_code,
    output logic            rx_we,
    output logic [BITS-1:0] rx_byte
);

    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

    srx_state_e      state;
    logic [CNT_W-1:0] bitcnt;
    logic [BITS-1:0] shreg;
    logic [7:0]      pend_code;
    logic            resume;
    logic            seen_rise;
    logic            addressed;
    logic            match;

    assign addressed = (state == ST_ACK) || (state == ST_HOLD) || (state == ST_DATA);
    assign match     = (shreg[BITS-1:1] == own_addr) && !shreg[0]
                       && aa && !sta_req && !sto_req;
    assign scl_hold  = (state == ST_HOLD);

    // Main receive sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            pend_code <= CODE_IDLE;
            resume    <= 1'b0;
            seen_rise <= 1'b0;
            sda_drive <= 1'b0;
            set_si    <= 1'b0;
            set_code  <= CODE_IDLE;
            rx_we     <= 1'b0;
            rx_byte   <= '0;
        end else begin
            set_si <= 1'b0;
            rx_we  <= 1'b0;
            if (!en) begin
                state     <= ST_IDLE;
                sda_drive <= 1'b0;
            end else if (start_det) begin
                if (addressed) begin
                    set_si   <= 1'b1;
                    set_code <= CODE_END;
                end
                state     <= ST_ADDR;
                bitcnt    <= '0;
                sda_drive <= 1'b0;
            end else if (stop_det) begin
                if (addressed) begin
                    set_si   <= 1'b1;
                    set_code <= CODE_END;
                end
                state     <= ST_IDLE;
                sda_drive <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise && bitcnt != LAST) begin
                            shreg  <= {shreg[BITS-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST) begin
                            if (match) begin
                                state     <= ST_ACK;
                                sda_drive <= 1'b1;
                                pend_code <= CODE_ADDR_ACK;
                                resume    <= 1'b1;
                                seen_rise <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DATA: begin
                        if (scl_rise && bitcnt != LAST) begin
                            shreg  <= {shreg[BITS-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST) begin
                            state     <= ST_ACK;
                            sda_drive <= aa;
                            pend_code <= aa ? CODE_DATA_ACK : CODE_DATA_NACK;
                            resume    <= aa;
                            seen_rise <= 1'b0;
                            rx_we     <= 1'b1;
                            rx_byte   <= shreg;
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise) begin
                            seen_rise <= 1'b1;
                        end else if (scl_fall && seen_rise) begin
                            sda_drive <= 1'b0;
                            set_si    <= 1'b1;
                            set_code  <= pend_code;
                            state     <= ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (!si && !set_si) begin
                            state  <= resume ? ST_DATA : ST_IDLE;
                            bitcnt <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_srx_regs.sv
// Host register file: own address, control with the interrupt flag,
// status view and last received byte. An engine flag set beats a host clear.
module i2c_srx_regs
    import i2c_srx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [1:0]      rd_idx,
    output logic [7:0]      rd_data,
    input  logic            set_si,
    input  logic [7:0]      set_code,
    input  logic            rx_we,
    input  logic [BITS-1:0] rx_byte,
    output logic            en,
    output logic            aa,
    output logic            sta_req,
    output logic            sto_req,
    output logic            si,
    output logic [BITS-2:0] own_addr,
    output logic [7:0]      stat_view
);

    logic [7:0]      status_q;
    logic [BITS-1:0] data_q;
    logic            unused_wr_bits;

    assign unused_wr_bits = ^wr_data[2:0];

    // Host writes to own address and control, engine events to flag/status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
            en       <= 1'b0;
            aa       <= 1'b0;
            sta_req  <= 1'b0;
            sto_req  <= 1'b0;
            si       <= 1'b0;
            status_q <= CODE_IDLE;
        end else begin
            if (wr_en && wr_idx == IDX_OWN) own_addr <= wr_data[7:1];
            if (wr_en && wr_idx == IDX_CTRL) begin
                en      <= wr_data[CB_EN];
                aa      <= wr_data[CB_AA];
                sta_req <= wr_data[CB_STA];
                sto_req <= wr_data[CB_STO];
                if (!wr_data[CB_FLAG]) si <= 1'b0;
            end
            if (set_si) begin
                si       <= 1'b1;
                status_q <= set_code;
            end
        end
    end

    // Capture each received byte for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_q <= '0;
        else if (rx_we) data_q <= rx_byte;
    end

    assign stat_view = si ? status_q : CODE_IDLE;

    // Combinational read mux.
    always_comb begin
        unique case (rd_idx)
            IDX_OWN:  rd_data = {own_addr, 1'b0};
            IDX_CTRL: rd_data = {en, aa, sta_req, sto_req, si, 3'b000};
            IDX_STAT: rd_data = stat_view;
            default:  rd_data = data_q;
        endcase
    end

endmodule

// File: rtl/i2c_target_rx.sv
// Top of the I2C slave receiver: synchroniser, condition detector,
// receive engine and host registers. Assumes an 8-bit host port.
module i2c_target_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       wr_en,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_idx,
    output logic [7:0] rd_data,
    output logic       irq
);

    localparam int BITS = 8;

    logic [1:0]      lines_s;
    logic            scl_rise, scl_fall, start_det, stop_det;
    logic            ctl_en, ctl_aa, ctl_sta, ctl_sto, flag;
    logic [BITS-2:0] own_addr;
    logic            set_si, rx_we;
    logic [7:0]      set_code, stat_view;
    logic [BITS-1:0] rx_byte;

    i2c_srx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({scl_i, sda_i}), .d_out(lines_s)
    );

    i2c_srx_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_srx_engine #(.BITS(BITS)) u_engine (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .aa(ctl_aa),
        .sta_req(ctl_sta), .sto_req(ctl_sto), .si(flag), .own_addr(own_addr),
        .sda_s(lines_s[0]), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_drive(sda_oe), .scl_hold(scl_oe), .set_si(set_si),
        .set_code(set_code), .rx_we(rx_we), .rx_byte(rx_byte)
    );

    i2c_srx_regs #(.BITS(BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .set_si(set_si), .set_code(set_code), .rx_we(rx_we), .rx_byte(rx_byte),
        .en(ctl_en), .aa(ctl_aa), .sta_req(ctl_sta), .sto_req(ctl_sto),
        .si(flag), .own_addr(own_addr), .stat_view(stat_view)
    );

    assign irq = flag;

endmodule

// File: rtl/i2c_target_rx_chk.sv
// Property checker for i2c_target_rx, attached by bind below.
module i2c_target_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       irq,
    input logic       ctl_en,
    input logic       ctl_aa,
    input logic [7:0] stat_view
);

    // R7
    hold_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |=> irq);

    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |=> !scl_oe);

    // R7
    drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_oe && scl_oe));

    // R2
    ack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> ($past(ctl_aa) && $past(ctl_en)));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !sda_oe);

    // R9
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_view == 8'h60 || stat_view == 8'h80 ||
                 stat_view == 8'h88 || stat_view == 8'hA0));

endmodule

bind i2c_target_rx i2c_target_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .ctl_en(ctl_en), .ctl_aa(ctl_aa), .stat_view(stat_view)
);

// File: tb/i2c_target_rx_test.sv
module i2c_target_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 6;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = 2'd0, rd_idx = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       scl_oe, sda_oe, irq;
    logic       scl_line, sda_line;
    logic [7:0] ctrl_sh = 8'h00;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_target_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] idx, output logic [7:0] d);
        @(negedge clk);
        rd_idx = idx;
        #1 d = rd_data;
    endtask

    task automatic set_ctrl(input logic [7:0] c);
        ctrl_sh = c;
        host_write(2'd1, c);
    endtask

    task automatic clear_flag;
        host_write(2'd1, ctrl_sh & 8'hF7);
    endtask

    task automatic wait_scl_high;
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; wait_scl_high(); tick(Q);
        b = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic nb;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(nb);
        acked = !nb;
    endtask

    task automatic expect_event(input string req, input logic [7:0] code);
        logic [7:0] s;
        check(req, {7'd0, irq}, 8'h01);
        host_read(2'd2, s);
        check(req, s, code);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       ack;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R9: reset state
        check("R9 irq", {7'd0, irq}, 8'h00);
        check("R9 oe", {6'd0, scl_oe, sda_oe}, 8'h00);
        host_read(2'd2, v); check("R9 status", v, 8'hF8);
        host_read(2'd1, v); check("R9 ctrl", v, 8'h00);

        // R1: bit 0 of own address reads 0
        host_write(2'd0, 8'hFF);
        host_read(2'd0, v); check("R1 own ff", v, 8'hFE);
        host_write(2'd0, {OWN, 1'b1});
        host_read(2'd0, v); check("R1 own", v, {OWN, 1'b0});
        set_ctrl(8'hC0);

        // R2/R3: sweep every address with both direction bits
        for (int a = 0; a < 128; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                logic [6:0] av;
                logic       exp_ack;
                av = 7'(a);
                exp_ack = (av == OWN) && (rw == 0);
                bus_start();
                send_byte({av, 1'(rw)}, ack);
                if (exp_ack) begin
                    check("R2 ack", {7'd0, ack}, 8'h01);
                    expect_event("R2 event", 8'h60);
                    check("R7 hold", {7'd0, scl_oe}, 8'h01);
                    clear_flag(); tick(3);
                    check("R7 release", {7'd0, scl_oe}, 8'h00);
                    bus_stop();
                    expect_event("R8 stop", 8'hA0);
                    clear_flag();
                end else begin
                    check("R3 nack", {7'd0, ack}, 8'h00);
                    check("R3 noflag", {7'd0, irq}, 8'h00);
                    bus_stop();
                    check("R3 stop quiet", {7'd0, irq}, 8'h00);
                end
            end
        end

        // R3: bytes after an unmatched address are ignored
        bus_start();
        send_byte({OWN ^ 7'h01, 1'b0}, ack);
        send_byte(8'h00, ack);
        check("R3 ignored byte", {7'd0, ack}, 8'h00);
        check("R3 ignored flag", {7'd0, irq}, 8'h00);
        bus_stop();

        // R4: data bytes acknowledged
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        expect_event("R2 addr", 8'h60);
        clear_flag();
        begin
            logic [7:0] pats [4];
            pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
            foreach (pats[k]) begin
                send_byte(pats[k], ack);
                check("R4 ack", {7'd0, ack}, 8'h01);
                expect_event("R4 status", 8'h80);
                host_read(2'd3, v); check("R4 data", v, pats[k]);
                clear_flag();
            end
        end

        // R5: clear ack-enable -> NACK, then unaddressed
        set_ctrl(8'h80);
        send_byte(8'h77, ack);
        check("R5 nack", {7'd0, ack}, 8'h00);
        expect_event("R5 status", 8'h88);
        host_read(2'd3, v); check("R5 data", v, 8'h77);
        clear_flag();
        send_byte(8'h11, ack);
        check("R5 ignored", {7'd0, ack}, 8'h00);
        check("R5 noflag", {7'd0, irq}, 8'h00);
        bus_stop();
        check("R5 stop quiet", {7'd0, irq}, 8'h00);

        // R6: isolated while ack-enable is 0, resumes when set
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R6 isolated", {7'd0, ack}, 8'h00);
        check("R6 noflag", {7'd0, irq}, 8'h00);
        bus_stop();
        set_ctrl(8'hC0);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R6 resumed", {7'd0, ack}, 8'h01);
        expect_event("R6 status", 8'h60);
        clear_flag();
        send_byte(8'h5C, ack);
        check("R4 after resume", {7'd0, ack}, 8'h01);
        expect_event("R4 status2", 8'h80);
        clear_flag();

        // R8: repeated start while addressed, then re-recognition
        bus_start();
        expect_event("R8 restart", 8'hA0);
        check("R8 no hold", {7'd0, scl_oe}, 8'h00);
        clear_flag();
        send_byte({OWN, 1'b0}, ack);
        check("R8 readdr ack", {7'd0, ack}, 8'h01);
        expect_event("R8 readdr", 8'h60);
        clear_flag();
        bus_stop();
        expect_event("R8 stop2", 8'hA0);
        clear_flag();

        // R2: disabled, and start request pending, both block recognition
        set_ctrl(8'h40);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R2 disabled", {7'd0, ack}, 8'h00);
        bus_stop();
        set_ctrl(8'hE0);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R2 sta pending", {7'd0, ack}, 8'h00);
        check("R2 sta noflag", {7'd0, irq}, 8'h00);
        bus_stop();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule